// File: doc/BRIEF.md
# Single-Precision Result Packer

This block turns an unpacked floating-point result into a 32-bit IEEE-754 single-precision word. The input has a class (zero, finite number, infinity or NaN), a sign, and a signed unbiased exponent. It also has a mantissa whose top bit is the explicit leading one. Below that bit sit the 23 fraction bits, then a guard bit and a round bit, then further low bits. A separate sticky input is merged with those low bits. An arithmetic unit places the block after its datapath. It presents one result per cycle with `in_valid` and takes the packed word and exception flags one cycle later.

For finite numbers the block works out the biased exponent. When that exponent is zero or below, it shifts the significand right into subnormal position and collects every bit it drops into the sticky bit. It then rounds under one of four modes and handles the carry that rounding can produce. That carry can turn 1.11…1 into 2.0, or lift the largest subnormal to the smallest normal. The block then applies the overflow policy, which depends on the mode. Each overflow resolves either to infinity or to the largest finite magnitude.

Top module: `fp32_result_packer`

## Requirements
- R1: A zero-class input (class code 0) packs to a zero with the input sign in bit 31, and raises no flag.
- R2: An infinity-class input (class code 2) packs to the input sign, exponent field 255 and fraction 0, and raises no flag.
- R3: A NaN-class input (class code 3) packs to exponent field 255. The fraction is the 23 mantissa bits directly below the leading one, with fraction bit 22 (the quiet bit) forced to 1. No flag is raised.
- R4: A finite input (class code 1) whose biased exponent (unbiased + 127) lies in 1..254 after rounding packs as sign in bit 31, biased exponent in bits 30:23 and rounded fraction in bits 22:0. In nearest mode (rm code 0) it rounds up when guard is set and round, sticky or the fraction LSB is set, so ties go to even.
- R5: Toward-zero mode (code 1) never rounds up. Toward +inf mode (code 2) rounds up any inexact positive value. Toward -inf mode (code 3) rounds up the magnitude of any inexact negative value.
- R6: The inexact flag (`flag_inexact`) is set when any discarded bit (guard, round, low mantissa bits, sticky or bits shifted out for a subnormal) is nonzero, and on every overflow.
- R7: When rounding a normal value carries the significand to 2.0, the exponent field goes up by one and the fraction field is 0.
- R8: When the biased exponent is 0 or below, the significand including the leading one is shifted right by (1 − biased exponent) before rounding, and the exponent field is 0. Such a result raises `flag_underflow` when it is inexact or when `uf_trap_en` is 1.
- R9: A subnormal that rounds up into the leading-one position packs to exponent field 1 and fraction 0, and raises no underflow flag.
- R10: A final biased exponent of 255 or more overflows. It goes to infinity in nearest mode, in +inf mode when positive, and in -inf mode when negative. Otherwise it goes to exponent 254 with an all-ones fraction. `flag_overflow` is set only when the delivered result is infinity.
- R11: Outputs are registered. `out_valid` equals `in_valid` one cycle later. The word and flags load only when `in_valid` is 1 and hold their value otherwise.
- R12: While reset is asserted, `out_valid`, `out_word` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input result is present this cycle |
| in_class | input | 2 | 0 zero, 1 finite, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign of the result |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_mant | input | MANT_W | Leading one, 23 fraction bits, guard, round, low bits |
| in_sticky | input | 1 | OR of bits below the mantissa |
| rnd_mode | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| uf_trap_en | input | 1 | Underflow trap enabled |
| out_valid | output | 1 | Registered result is present |
| out_word | output | 32 | Packed single-precision word |
| flag_overflow | output | 1 | Overflow delivered as infinity |
| flag_underflow | output | 1 | Tiny result per R8 |
| flag_inexact | output | 1 | Result differs from the exact value |

## Verification
The hardest situations to reach are those where rounding carries across a boundary. One is the largest subnormal, which must become the smallest normal and drop its underflow flag. The other is the largest normal, which rounds into overflow and must then follow the mode and sign. The stimulus reaches both with mantissas of all-ones fraction with only the guard bit set, placed at exponent −127 and exponent 127. It repeats them under several modes and signs. Deep subnormal shifts that clamp the shifter are driven with exponents far below −149.

// File: rtl/fp32pk_pkg.sv
`timescale 1ns/1ps
package fp32pk_pkg;
  localparam int FRAC_W   = 23;
  localparam int SIG_W    = FRAC_W + 1;
  localparam int EXP_BIAS = 127;
  localparam int EXP_TOP  = 255;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_POS  = 2'd2,
    RM_NEG  = 2'd3
  } rmode_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic inx;
  } flags_t;
endpackage

// File: rtl/fp32pk_align.sv
`timescale 1ns/1ps
// Biased exponent, subnormal detection and right alignment with sticky collection.
module fp32pk_align
  import fp32pk_pkg::*;
#(
  parameter int EXP_W  = 10,
  parameter int MANT_W = 28   // must be at least SIG_W + 3
) (
  input  logic [EXP_W-1:0]        exp_i,
  input  logic [MANT_W-1:0]       mant_i,
  input  logic                    sticky_i,
  output logic signed [EXP_W:0]   be_o,
  output logic                    sub_o,
  output logic [SIG_W-1:0]        sig_o,
  output logic                    guard_o,
  output logic                    round_o,
  output logic                    sticky_o
);
  localparam int BE_W = EXP_W + 1;
  localparam int SHW  = $clog2(MANT_W + 1);
  localparam int LOW_W = MANT_W - SIG_W - 2;

  logic signed [BE_W-1:0] be;
  logic signed [BE_W-1:0] sh_raw;
  logic [SHW-1:0]         sh;

  always_comb begin
    be     = $signed({exp_i[EXP_W-1], exp_i}) + $signed(BE_W'(EXP_BIAS));
    sub_o  = be < $signed(BE_W'(1));
    sh_raw = $signed(BE_W'(1)) - be;
    if (!sub_o) begin
      sh = '0;
    end else if (sh_raw > $signed(BE_W'(MANT_W))) begin
      sh = SHW'(MANT_W);
    end else begin
      sh = sh_raw[SHW-1:0];
    end
  end

  // log-depth right shifter; each stage records whether it dropped a one
  logic [MANT_W-1:0] stage [SHW+1];
  logic              lost  [SHW+1];

  assign stage[0] = mant_i;
  assign lost[0]  = 1'b0;

  for (genvar k = 0; k < SHW; k++) begin : g_shift
    localparam int AMT = 1 << k;
    localparam logic [MANT_W-1:0] DROP = ~({MANT_W{1'b1}} << AMT);
    assign stage[k+1] = sh[k] ? (stage[k] >> AMT) : stage[k];
    assign lost[k+1]  = lost[k] | (sh[k] & (|(stage[k] & DROP)));
  end

  logic [MANT_W-1:0] aligned;
  logic [LOW_W-1:0]  low_bits;

  always_comb begin
    aligned  = stage[SHW];
    be_o     = be;
    sig_o    = aligned[MANT_W-1 -: SIG_W];
    guard_o  = aligned[MANT_W-SIG_W-1];
    round_o  = aligned[MANT_W-SIG_W-2];
    low_bits = aligned[LOW_W-1:0];
    sticky_o = (|low_bits) | lost[SHW] | sticky_i;
  end

  // R8: a subnormal shift always clears the leading-one position
  always_comb begin
    if (sub_o) begin
      p_sub_lead_clear_r8: assert (!sig_o[SIG_W-1]);
    end
  end
endmodule

// File: rtl/fp32pk_round.sv
`timescale 1ns/1ps
// Four-mode rounding of the aligned significand.
module fp32pk_round
  import fp32pk_pkg::*;
(
  input  logic [SIG_W-1:0] sig_i,
  input  logic             guard_i,
  input  logic             round_i,
  input  logic             sticky_i,
  input  logic             sign_i,
  input  rmode_e           rm_i,
  output logic [SIG_W:0]   rnd_o,
  output logic             inexact_o
);
  logic up;

  always_comb begin
    inexact_o = guard_i | round_i | sticky_i;
    unique case (rm_i)
      RM_NEAR: up = guard_i & (round_i | sticky_i | sig_i[0]);
      RM_ZERO: up = 1'b0;
      RM_POS:  up = inexact_o & ~sign_i;
      RM_NEG:  up = inexact_o & sign_i;
      default: up = 1'b0;
    endcase
    rnd_o = {1'b0, sig_i} + {{SIG_W{1'b0}}, up};
  end

  // R6: a round-up can only come from an inexact value
  always_comb begin
    p_up_needs_inexact_r6: assert (!up || inexact_o);
  end
endmodule

// File: rtl/fp32pk_assemble.sv
`timescale 1ns/1ps
// Special classes, exponent carry, overflow policy and flag generation.
module fp32pk_assemble
  import fp32pk_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  cls_e                  cls_i,
  input  logic                  sign_i,
  input  logic signed [EXP_W:0] be_i,
  input  logic                  sub_i,
  input  logic [SIG_W:0]        rnd_i,
  input  logic                  inexact_i,
  input  logic [FRAC_W-1:0]     nan_frac_i,
  input  rmode_e                rm_i,
  input  logic                  trap_i,
  output logic [31:0]           word_o,
  output flags_t                flags_o
);
  localparam int FE_W = EXP_W + 2;

  logic signed [FE_W-1:0] exp_fin;
  logic                   ovf_cond;
  logic                   to_inf;
  logic [FRAC_W-1:0]      quiet_mask;

  always_comb begin
    exp_fin    = $signed({be_i[EXP_W], be_i}) + $signed({{(FE_W-1){1'b0}}, rnd_i[SIG_W]});
    ovf_cond   = exp_fin >= $signed(FE_W'(EXP_TOP));
    quiet_mask = {1'b1, {(FRAC_W-1){1'b0}}};
    unique case (rm_i)
      RM_NEAR: to_inf = 1'b1;
      RM_ZERO: to_inf = 1'b0;
      RM_POS:  to_inf = ~sign_i;
      RM_NEG:  to_inf = sign_i;
      default: to_inf = 1'b1;
    endcase
  end

  always_comb begin
    word_o  = {sign_i, 31'd0};
    flags_o = '0;
    unique case (cls_i)
      CLS_ZERO: word_o = {sign_i, 31'd0};
      CLS_INF:  word_o = {sign_i, 8'hFF, {FRAC_W{1'b0}}};
      CLS_NAN:  word_o = {sign_i, 8'hFF, nan_frac_i | quiet_mask};
      CLS_NUM: begin
        flags_o.inx = inexact_i;
        if (sub_i) begin
          // carry into bit FRAC_W lands in the exponent field as a 1
          word_o = {sign_i, 7'd0, rnd_i[FRAC_W], rnd_i[FRAC_W-1:0]};
          flags_o.unf = ~rnd_i[FRAC_W] & (inexact_i | trap_i);
        end else if (ovf_cond) begin
          flags_o.inx = 1'b1;
          flags_o.ovf = to_inf;
          word_o = to_inf ? {sign_i, 8'hFF, {FRAC_W{1'b0}}}
                          : {sign_i, 8'hFE, {FRAC_W{1'b1}}};
        end else begin
          word_o = {sign_i, exp_fin[7:0], rnd_i[FRAC_W-1:0]};
        end
      end
      default: word_o = {sign_i, 31'd0};
    endcase
  end

  // R10: a finite input reaches exponent 255 only as an overflow to infinity
  always_comb begin
    if (cls_i == CLS_NUM && word_o[30:23] == 8'hFF) begin
      p_num_top_exp_r10: assert (flags_o.ovf);
    end
  end
endmodule

// File: rtl/fp32_result_packer.sv
`timescale 1ns/1ps
module fp32_result_packer
  import fp32pk_pkg::*;
#(
  parameter int EXP_W  = 10,
  parameter int MANT_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_class,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  input  logic              in_sticky,
  input  logic [1:0]        rnd_mode,
  input  logic              uf_trap_en,
  output logic              out_valid,
  output logic [31:0]       out_word,
  output logic              flag_overflow,
  output logic              flag_underflow,
  output logic              flag_inexact
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  cls_e   cls;
  rmode_e rm;
  assign cls = cls_e'(in_class);
  assign rm  = rmode_e'(rnd_mode);

  logic signed [EXP_W:0] be;
  logic                  sub;
  logic [SIG_W-1:0]      sig;
  logic                  grd, rnd_bit, stk;
  logic [SIG_W:0]        rounded;
  logic                  inexact;
  logic [31:0]           word_c;
  flags_t                flags_c;

  fp32pk_align #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_align (
    .exp_i    (in_exp),
    .mant_i   (in_mant),
    .sticky_i (in_sticky),
    .be_o     (be),
    .sub_o    (sub),
    .sig_o    (sig),
    .guard_o  (grd),
    .round_o  (rnd_bit),
    .sticky_o (stk)
  );

  fp32pk_round u_round (
    .sig_i     (sig),
    .guard_i   (grd),
    .round_i   (rnd_bit),
    .sticky_i  (stk),
    .sign_i    (in_sign),
    .rm_i      (rm),
    .rnd_o     (rounded),
    .inexact_o (inexact)
  );

  fp32pk_assemble #(.EXP_W(EXP_W)) u_assemble (
    .cls_i      (cls),
    .sign_i     (in_sign),
    .be_i       (be),
    .sub_i      (sub),
    .rnd_i      (rounded),
    .inexact_i  (inexact),
    .nan_frac_i (in_mant[MANT_W-2 -: FRAC_W]),
    .rm_i       (rm),
    .trap_i     (uf_trap_en),
    .word_o     (word_c),
    .flags_o    (flags_c)
  );

  // next-state
  logic        valid_d;
  logic [31:0] word_d;
  flags_t      flags_d, flags_q;

  always_comb begin
    valid_d = in_valid;
    word_d  = out_word;
    flags_d = flags_q;
    if (in_valid) begin
      word_d  = word_c;
      flags_d = flags_c;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      flags_q   <= '0;
    end else begin
      out_valid <= valid_d;
      out_word  <= word_d;
      flags_q   <= flags_d;
    end
  end

  assign flag_overflow  = flags_q.ovf;
  assign flag_underflow = flags_q.unf;
  assign flag_inexact   = flags_q.inx;

  p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  p_idle_follows_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
  p_hold_word_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(out_word) && $stable(flags_q));
  p_ovf_is_inf_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flag_overflow |-> out_word[30:0] == 31'h7F80_0000);
  p_ovf_inexact_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flag_overflow |-> flag_inexact);
  p_unf_is_tiny_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flag_underflow |-> out_word[30:23] == 8'd0);
endmodule

// File: tb/test_fp32_result_packer.sv
`timescale 1ns/1ps
module test_fp32_result_packer;
  localparam int EW = 10;
  localparam int MW = 28;
  localparam int WATCHDOG = 200000;

  typedef struct packed {
    logic [1:0]    rm;
    logic          trap;
    logic [1:0]    cls;
    logic          sgn;
    logic [EW-1:0] ex;
    logic [MW-1:0] mt;
    logic          st;
    logic [31:0]   word;
    logic [2:0]    flg;   // {overflow, underflow, inexact}
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{2'd0,1'b0,2'd0,1'b1, 10'sd0,    28'h0000000,1'b0,32'h8000_0000,3'b000}, // R1 negative zero
    '{2'd1,1'b1,2'd0,1'b0, 10'sd5,    28'h8000000,1'b1,32'h0000_0000,3'b000}, // R1 positive zero
    '{2'd0,1'b0,2'd2,1'b0, 10'sd0,    28'h8000000,1'b0,32'h7F80_0000,3'b000}, // R2 +inf
    '{2'd3,1'b0,2'd2,1'b1, 10'sd0,    28'h0000000,1'b1,32'hFF80_0000,3'b000}, // R2 -inf
    '{2'd0,1'b0,2'd3,1'b1, 10'sd0,    28'h8123450,1'b0,32'hFFC1_2345,3'b000}, // R3 signalling payload
    '{2'd1,1'b0,2'd3,1'b0, 10'sd0,    28'hC00ABC0,1'b0,32'h7FC0_0ABC,3'b000}, // R3 quiet payload
    '{2'd0,1'b0,2'd1,1'b0, 10'sd0,    28'h8000000,1'b0,32'h3F80_0000,3'b000}, // R4 exact 1.0
    '{2'd0,1'b0,2'd1,1'b0, 10'sd0,    28'h8000018,1'b0,32'h3F80_0002,3'b001}, // R4 tie odd up
    '{2'd0,1'b0,2'd1,1'b0, 10'sd0,    28'h8000008,1'b0,32'h3F80_0000,3'b001}, // R4 tie even down
    '{2'd0,1'b0,2'd1,1'b0, 10'sd0,    28'h8000004,1'b0,32'h3F80_0000,3'b001}, // R4 below half
    '{2'd1,1'b0,2'd1,1'b0, 10'sd0,    28'h800001C,1'b0,32'h3F80_0001,3'b001}, // R5 toward zero
    '{2'd2,1'b0,2'd1,1'b0, 10'sd0,    28'h8000000,1'b1,32'h3F80_0001,3'b001}, // R5 +inf positive
    '{2'd2,1'b0,2'd1,1'b1, 10'sd0,    28'h8000000,1'b1,32'hBF80_0000,3'b001}, // R5 +inf negative
    '{2'd3,1'b0,2'd1,1'b1, 10'sd0,    28'h8000001,1'b0,32'hBF80_0001,3'b001}, // R5 -inf negative
    '{2'd3,1'b0,2'd1,1'b0, 10'sd0,    28'h8000002,1'b0,32'h3F80_0000,3'b001}, // R5 -inf positive
    '{2'd0,1'b0,2'd1,1'b0, 10'sd0,    28'hFFFFFF8,1'b0,32'h4000_0000,3'b001}, // R7 carry to 2.0
    '{2'd0,1'b0,2'd1,1'b0, 10'sd127,  28'hFFFFFF0,1'b0,32'h7F7F_FFFF,3'b000}, // R4 largest finite
    '{2'd0,1'b0,2'd1,1'b0, 10'sd127,  28'hFFFFFF8,1'b0,32'h7F80_0000,3'b101}, // R10 carry overflow nearest
    '{2'd1,1'b0,2'd1,1'b0, 10'sd127,  28'hFFFFFF8,1'b0,32'h7F7F_FFFF,3'b001}, // R5 no carry toward zero
    '{2'd1,1'b0,2'd1,1'b0, 10'sd128,  28'h8000000,1'b0,32'h7F7F_FFFF,3'b001}, // R10 toward zero saturates
    '{2'd2,1'b0,2'd1,1'b1, 10'sd128,  28'h8000000,1'b0,32'hFF7F_FFFF,3'b001}, // R10 +inf negative saturates
    '{2'd3,1'b0,2'd1,1'b1, 10'sd128,  28'h8000000,1'b0,32'hFF80_0000,3'b101}, // R10 -inf negative to inf
    '{2'd0,1'b0,2'd1,1'b0, 10'sd300,  28'h8000000,1'b0,32'h7F80_0000,3'b101}, // R10 far overflow
    '{2'd0,1'b0,2'd1,1'b0,-10'sd126,  28'h8000000,1'b0,32'h0080_0000,3'b000}, // R4 smallest normal
    '{2'd0,1'b0,2'd1,1'b0,-10'sd127,  28'h8000000,1'b0,32'h0040_0000,3'b000}, // R8 exact subnormal
    '{2'd0,1'b1,2'd1,1'b0,-10'sd127,  28'h8000000,1'b0,32'h0040_0000,3'b010}, // R8 trap enable
    '{2'd0,1'b0,2'd1,1'b0,-10'sd127,  28'h8000010,1'b0,32'h0040_0000,3'b011}, // R8 shifted-out tie
    '{2'd0,1'b0,2'd1,1'b0,-10'sd127,  28'hFFFFFF0,1'b0,32'h0080_0000,3'b001}, // R9 promote to normal
    '{2'd1,1'b0,2'd1,1'b0,-10'sd127,  28'hFFFFFF0,1'b0,32'h007F_FFFF,3'b011}, // R9 stays subnormal
    '{2'd2,1'b0,2'd1,1'b0,-10'sd200,  28'h8000000,1'b0,32'h0000_0001,3'b011}  // R8 deep shift +inf
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [1:0]    in_class;
  logic          in_sign;
  logic [EW-1:0] in_exp;
  logic [MW-1:0] in_mant;
  logic          in_sticky;
  logic [1:0]    rnd_mode;
  logic          uf_trap_en;
  logic          out_valid;
  logic [31:0]   out_word;
  logic          flag_overflow, flag_underflow, flag_inexact;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fp32_result_packer #(.EXP_W(EW), .MANT_W(MW)) i_fp32_result_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
    .rnd_mode(rnd_mode), .uf_trap_en(uf_trap_en), .out_valid(out_valid),
    .out_word(out_word), .flag_overflow(flag_overflow),
    .flag_underflow(flag_underflow), .flag_inexact(flag_inexact)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    in_valid   = vld;
    rnd_mode   = v.rm;
    uf_trap_en = v.trap;
    in_class   = v.cls;
    in_sign    = v.sgn;
    in_exp     = v.ex;
    in_mant    = v.mt;
    in_sticky  = v.st;
  endtask

  function automatic logic [31:0] flags_now();
    return {29'd0, flag_overflow, flag_underflow, flag_inexact};
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(VECS[6], 1'b0);
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R12 out_word", out_word, 32'd0);
    chk("R12 flags", flags_now(), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i], 1'b1);
      @(negedge clk);
      chk($sformatf("R11 valid vec%0d", i), {31'd0, out_valid}, 32'd1);
      chk($sformatf("word vec%0d (see table tag)", i), out_word, VECS[i].word);
      chk($sformatf("flags vec%0d (see table tag)", i), flags_now(), {29'd0, VECS[i].flg});
    end

    // R11: with in_valid low, a new input must not reach the outputs
    drive(VECS[22], 1'b0);
    @(negedge clk);
    chk("R11 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R11 word held", out_word, VECS[NV-1].word);
    chk("R11 flags held", flags_now(), {29'd0, VECS[NV-1].flg});
    @(negedge clk);
    chk("R11 word still held", out_word, VECS[NV-1].word);

    // R11 back-to-back results, one per cycle
    drive(VECS[17], 1'b1);
    @(negedge clk);
    chk("R11 b2b first", out_word, VECS[17].word);
    drive(VECS[27], 1'b1);
    @(negedge clk);
    chk("R11 b2b second", out_word, VECS[27].word);
    chk("R9 b2b flags", flags_now(), {29'd0, VECS[27].flg});
    drive(VECS[0], 1'b0);

    // R12 reset during operation clears outputs at once
    #3 rst_n = 1'b0;
    #2;
    chk("R12 mid reset word", out_word, 32'd0);
    chk("R12 mid reset flags", flags_now(), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 after release valid", {31'd0, out_valid}, 32'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule